// File: doc/BRIEF.md
# Fault-Injectable Programmable Logic Array

This block is a small two-plane programmable logic array with three inputs, four product terms and three outputs. Each input drives two bit lines, one true and one inverted. An AND crosspoint mask selects which bit lines each product line uses. An OR crosspoint mask selects which product lines feed each output. The personality sits in registers that come out of reset with a default function. Software-free test benches can reload it one row at a time.

Beside the fault-free array, the block evaluates a faulty twin. The twin uses a shadow copy of the personality in which one crosspoint, named by a fault descriptor, is forced present or absent. Depending on the plane and the direction, that single change gives growth, shrinkage, disappearance or appearance behaviour. The twin can also carry one stuck-at-0 or stuck-at-1 fault on one of four kinds of line: an input line, an inverter output, a product line or an output line.

Both output sets are presented, together with a per-output mismatch vector. A fault-simulation or test-pattern experiment can then see directly which vectors detect the injected fault.

Top module: `pla_fault_inject`

## Requirements
- R1: While reset is asserted, and after it is released, the personality holds its default. Bit line 2i is input i true and bit line 2i+1 is input i inverted. The product rows hold the bit-line sets P0={0,2}, P1={2,5}, P2={3,4} and P3={1,4}. The outputs are Y0=P0|P1, Y1=P2|P3 and Y2=P0|P3, where OR-mask bit j selects product j.
- R2: A product line is the AND of the bit lines whose AND-mask bits are set. A product line with an all-zero mask evaluates to 1.
- R3: An output is the OR of the product lines whose OR-mask bits are set. An output with an all-zero mask evaluates to 0.
- R4: When the write strobe is high at a rising clock edge, the addressed row is loaded, and the new function is visible from that edge onward. Plane 0 is the AND plane and takes 6 data bits. Plane 1 is the OR plane and takes the low 4 data bits. A row beyond the plane's row count is ignored.
- R5: An AND-plane fault that removes a crosspoint drops that literal from the product in the faulty copy only, so the product grows.
- R6: An AND-plane fault that adds a crosspoint adds that literal to the product in the faulty copy. The product shrinks, or becomes constant 0 when the added literal conflicts with one already present.
- R7: An OR-plane fault that removes a crosspoint drops the product from the output (disappearance). One that adds a crosspoint ORs the product into the output (appearance).
- R8: A fault descriptor never changes the fault-free outputs or the stored personality. A descriptor whose row or column lies outside its plane has no effect.
- R9: The stuck-at injection forces the chosen line of the faulty copy to the stuck value. Site code 0 selects input i (true bit line), 1 selects the inverter of input i, 2 selects product j and 3 selects output k. An index outside the site's range has no effect.
- R10: The mismatch output is the bitwise XOR of the fault-free and faulty outputs.
- R11: With both injection enables low, the faulty outputs equal the fault-free outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, restores the default personality |
| xIn | input | 3 | Array inputs |
| persWe | input | 1 | Personality row write strobe |
| persPlane | input | 1 | Plane of the write: 0 AND, 1 OR |
| persRow | input | 2 | Row written (product for AND, output for OR) |
| persData | input | 6 | Row mask; OR rows use the low 4 bits |
| faultEn | input | 1 | Enables the crosspoint fault |
| faultPlane | input | 1 | Fault plane: 0 AND, 1 OR |
| faultRow | input | 2 | Row of the faulty crosspoint |
| faultCol | input | 3 | Column of the faulty crosspoint (bit line or product) |
| faultAdd | input | 1 | 1 forces the crosspoint present, 0 absent |
| stuckEn | input | 1 | Enables the stuck-at fault |
| stuckSite | input | 2 | 0 input, 1 inverter, 2 product, 3 output |
| stuckIdx | input | 3 | Index within the site |
| stuckVal | input | 1 | Stuck level |
| yGood | output | 3 | Fault-free outputs |
| yFault | output | 3 | Outputs of the faulty copy |
| mismatch | output | 3 | Per-output difference between the two |

## Verification
Every input vector is swept under the default personality. This separates the true and inverted bit lines and the sharing of product P0 between two outputs. The sweep is repeated with an emptied product row and an emptied output row, which exposes the constant-1 and constant-0 rules. It is repeated again after a write to a nonexistent row, which shows that the write was dropped. Every crosspoint of both planes is then forced present and absent, each under all eight vectors. Vectors that activate a growth, shrinkage or appearance show a mismatch, and vectors that cannot activate the fault show none. Finally, each stuck-at site and level is swept with all vectors, including out-of-range indices that must leave the faulty copy equal to the fault-free one.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int NIN     = 3;
  localparam int NPROD   = 4;
  localparam int NOUT    = 3;
  localparam int NBIT    = 2 * NIN;
  localparam int WDATA   = (NBIT > NPROD) ? NBIT : NPROD;
  localparam int NROWMAX = (NPROD > NOUT) ? NPROD : NOUT;
  localparam int ROWW    = $clog2(NROWMAX);
  localparam int COLW    = $clog2(WDATA);
  localparam int PCOLW   = $clog2(NPROD);
  localparam int OROWW   = $clog2(NOUT);

  typedef logic [NPROD-1:0][NBIT-1:0]  andPlane_t;
  typedef logic [NOUT-1:0][NPROD-1:0]  orPlane_t;

  typedef enum logic [1:0] {
    SITE_IN   = 2'd0,
    SITE_INV  = 2'd1,
    SITE_PROD = 2'd2,
    SITE_OUT  = 2'd3
  } site_e;

  // strobes from control to the faulty evaluation datapath
  typedef struct packed {
    logic [NBIT-1:0]  bitHit;
    logic [NPROD-1:0] prodHit;
    logic [NOUT-1:0]  outHit;
    logic             level;
  } stuckStrobe_t;

  // row 3 .. row 0
  localparam andPlane_t AND_DEFAULT = {6'b010010, 6'b011000, 6'b100100, 6'b000101};
  localparam orPlane_t  OR_DEFAULT  = {4'b1001, 4'b1100, 4'b0011};
endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             persWe,
  input  logic             persPlane,
  input  logic [ROWW-1:0]  persRow,
  input  logic [WDATA-1:0] persData,
  input  logic             faultEn,
  input  logic             faultPlane,
  input  logic [ROWW-1:0]  faultRow,
  input  logic [COLW-1:0]  faultCol,
  input  logic             faultAdd,
  input  logic             stuckEn,
  input  logic [1:0]       stuckSite,
  input  logic [COLW-1:0]  stuckIdx,
  input  logic             stuckVal,
  output andPlane_t        andGood,
  output andPlane_t        andFault,
  output orPlane_t         orGood,
  output orPlane_t         orFault,
  output stuckStrobe_t     stb
);
  andPlane_t andReg;
  orPlane_t  orReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      andReg <= AND_DEFAULT;
      orReg  <= OR_DEFAULT;
    end else if (persWe) begin
      if (!persPlane && int'(persRow) < NPROD)
        andReg[persRow] <= persData[NBIT-1:0];
      else if (persPlane && int'(persRow) < NOUT)
        orReg[persRow[OROWW-1:0]] <= persData[NPROD-1:0];
    end
  end

  assign andGood = andReg;
  assign orGood  = orReg;

  // shadow personality with one crosspoint forced
  always_comb begin
    andFault = andReg;
    orFault  = orReg;
    if (faultEn) begin
      if (!faultPlane) begin
        if (int'(faultRow) < NPROD && int'(faultCol) < NBIT)
          andFault[faultRow][faultCol] = faultAdd;
      end else begin
        if (int'(faultRow) < NOUT && int'(faultCol) < NPROD)
          orFault[faultRow[OROWW-1:0]][faultCol[PCOLW-1:0]] = faultAdd;
      end
    end
  end

  always_comb begin
    stb.level   = stuckVal;
    stb.bitHit  = '0;
    stb.prodHit = '0;
    stb.outHit  = '0;
    for (int i = 0; i < NIN; i++) begin
      stb.bitHit[2*i]   = stuckEn && (stuckSite == SITE_IN)  && (stuckIdx == COLW'(i));
      stb.bitHit[2*i+1] = stuckEn && (stuckSite == SITE_INV) && (stuckIdx == COLW'(i));
    end
    for (int j = 0; j < NPROD; j++)
      stb.prodHit[j] = stuckEn && (stuckSite == SITE_PROD) && (stuckIdx == COLW'(j));
    for (int k = 0; k < NOUT; k++)
      stb.outHit[k] = stuckEn && (stuckSite == SITE_OUT) && (stuckIdx == COLW'(k));
  end

  // R4: personality only moves under the write strobe
  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !persWe |=> ($stable(andReg) && $stable(orReg)));

  // R8: shadow copy differs from the stored personality in at most one crosspoint
  a_r8_single_crosspoint: assert property (@(posedge clk) disable iff (!rstN)
    $countones({andGood ^ andFault, orGood ^ orFault}) <= 1);

  // R9: at most one line is stuck at a time
  a_r9_one_stuck_line: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.bitHit, stb.prodHit, stb.outHit}));
endmodule

// File: rtl/pla_eval.sv
module pla_eval
  import pla_pkg::*;
(
  input  logic [NIN-1:0]  xIn,
  input  andPlane_t       andPlane,
  input  orPlane_t        orPlane,
  input  stuckStrobe_t    stb,
  output logic [NOUT-1:0] y
);
  logic [NBIT-1:0]  bitLine;
  logic [NPROD-1:0] prodLine;

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      bitLine[2*i]   = xIn[i];
      bitLine[2*i+1] = ~xIn[i];
    end
    for (int b = 0; b < NBIT; b++)
      if (stb.bitHit[b]) bitLine[b] = stb.level;
  end

  always_comb begin
    for (int j = 0; j < NPROD; j++) begin
      prodLine[j] = &(bitLine | ~andPlane[j]);
      if (stb.prodHit[j]) prodLine[j] = stb.level;
    end
  end

  always_comb begin
    for (int k = 0; k < NOUT; k++) begin
      y[k] = |(prodLine & orPlane[k]);
      if (stb.outHit[k]) y[k] = stb.level;
    end
  end
endmodule

// File: rtl/pla_fault_inject.sv
module pla_fault_inject
  import pla_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIN-1:0]   xIn,
  input  logic             persWe,
  input  logic             persPlane,
  input  logic [ROWW-1:0]  persRow,
  input  logic [WDATA-1:0] persData,
  input  logic             faultEn,
  input  logic             faultPlane,
  input  logic [ROWW-1:0]  faultRow,
  input  logic [COLW-1:0]  faultCol,
  input  logic             faultAdd,
  input  logic             stuckEn,
  input  logic [1:0]       stuckSite,
  input  logic [COLW-1:0]  stuckIdx,
  input  logic             stuckVal,
  output logic [NOUT-1:0]  yGood,
  output logic [NOUT-1:0]  yFault,
  output logic [NOUT-1:0]  mismatch
);
  andPlane_t    andGood, andFault;
  orPlane_t     orGood, orFault;
  stuckStrobe_t stb;

  pla_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .persWe(persWe), .persPlane(persPlane), .persRow(persRow), .persData(persData),
    .faultEn(faultEn), .faultPlane(faultPlane), .faultRow(faultRow),
    .faultCol(faultCol), .faultAdd(faultAdd),
    .stuckEn(stuckEn), .stuckSite(stuckSite), .stuckIdx(stuckIdx), .stuckVal(stuckVal),
    .andGood(andGood), .andFault(andFault), .orGood(orGood), .orFault(orFault),
    .stb(stb)
  );

  pla_eval u_good (
    .xIn(xIn), .andPlane(andGood), .orPlane(orGood), .stb('0), .y(yGood)
  );

  pla_eval u_faulty (
    .xIn(xIn), .andPlane(andFault), .orPlane(orFault), .stb(stb), .y(yFault)
  );

  assign mismatch = yGood ^ yFault;

  // R11: no injection means the twins agree
  a_r11_twins_agree: assert property (@(posedge clk) disable iff (!rstN)
    (!faultEn && !stuckEn) |-> (yFault == yGood));

  // R9: a stuck output line shows the stuck level
  a_r9_output_stuck: assert property (@(posedge clk) disable iff (!rstN)
    (stuckEn && stuckSite == SITE_OUT && int'(stuckIdx) < NOUT)
      |-> (yFault[stuckIdx[OROWW-1:0]] == stuckVal));
endmodule

// File: tb/pla_fault_inject_tb.sv
module pla_fault_inject_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] xIn = '0;
  logic       persWe = 0, persPlane = 0;
  logic [1:0] persRow = '0;
  logic [5:0] persData = '0;
  logic       faultEn = 0, faultPlane = 0, faultAdd = 0;
  logic [1:0] faultRow = '0;
  logic [2:0] faultCol = '0;
  logic       stuckEn = 0, stuckVal = 0;
  logic [1:0] stuckSite = '0;
  logic [2:0] stuckIdx = '0;
  logic [2:0] yGood, yFault, mismatch;

  int    nChecks = 0, nFails = 0;
  string curTag = "R1";
  bit    done = 0;

  int mAnd[4][6];
  int mOr[3][4];

  always #10 clk = ~clk;

  pla_fault_inject u_dut (
    .clk(clk), .rstN(rstN), .xIn(xIn),
    .persWe(persWe), .persPlane(persPlane), .persRow(persRow), .persData(persData),
    .faultEn(faultEn), .faultPlane(faultPlane), .faultRow(faultRow),
    .faultCol(faultCol), .faultAdd(faultAdd),
    .stuckEn(stuckEn), .stuckSite(stuckSite), .stuckIdx(stuckIdx), .stuckVal(stuckVal),
    .yGood(yGood), .yFault(yFault), .mismatch(mismatch)
  );

  task automatic loadDefaults();
    foreach (mAnd[r, c]) mAnd[r][c] = 0;
    foreach (mOr[r, c])  mOr[r][c]  = 0;
    mAnd[0][0] = 1; mAnd[0][2] = 1;   // x0 & x1
    mAnd[1][2] = 1; mAnd[1][5] = 1;   // x1 & ~x2
    mAnd[2][3] = 1; mAnd[2][4] = 1;   // ~x1 & x2
    mAnd[3][1] = 1; mAnd[3][4] = 1;   // ~x0 & x2
    mOr[0][0] = 1; mOr[0][1] = 1;
    mOr[1][2] = 1; mOr[1][3] = 1;
    mOr[2][0] = 1; mOr[2][3] = 1;
  endtask

  // reference personality, R1 and R4
  always @(posedge clk or negedge rstN) begin
    if (!rstN) loadDefaults();
    else if (persWe) begin
      if (persPlane == 0 && persRow < 4)
        for (int c = 0; c < 6; c++) mAnd[persRow][c] = persData[c];
      else if (persPlane == 1 && persRow < 3)
        for (int c = 0; c < 4; c++) mOr[persRow][c] = persData[c];
    end
  end

  function automatic logic [2:0] refEval(input logic [2:0] xv, input int a[4][6],
                                         input int o[3][4], input int site, input int idx,
                                         input int lvl);
    int tv[3], cv[3], p[4];
    logic [2:0] r;
    for (int i = 0; i < 3; i++) begin
      tv[i] = xv[i];
      cv[i] = 1 - xv[i];
      if (site == 0 && idx == i) tv[i] = lvl;
      if (site == 1 && idx == i) cv[i] = lvl;
    end
    for (int j = 0; j < 4; j++) begin
      p[j] = 1;
      for (int b = 0; b < 6; b++)
        if (a[j][b] != 0) begin
          if ((b % 2) == 0) p[j] = p[j] * tv[b/2];
          else              p[j] = p[j] * cv[b/2];
        end
      if (site == 2 && idx == j) p[j] = lvl;
    end
    for (int k = 0; k < 3; k++) begin
      int acc = 0;
      for (int j = 0; j < 4; j++) if (o[k][j] != 0 && p[j] != 0) acc = 1;
      if (site == 3 && idx == k) acc = lvl;
      r[k] = (acc != 0);
    end
    return r;
  endfunction

  task automatic checkOne(string what, string tag, logic [2:0] act, logic [2:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s x=%0d actual=%b expected=%b", tag, what, xIn, act, exp);
    end
  endtask

  task automatic compareNow();
    int fa[4][6];
    int fo[3][4];
    int site;
    logic [2:0] eg, ef;
    fa = mAnd;
    fo = mOr;
    if (faultEn) begin
      if (faultPlane == 0 && faultRow < 4 && faultCol < 6) fa[faultRow][faultCol] = faultAdd;
      if (faultPlane == 1 && faultRow < 3 && faultCol < 4) fo[faultRow][faultCol] = faultAdd;
    end
    site = stuckEn ? int'(stuckSite) : -1;
    eg = refEval(xIn, mAnd, mOr, -1, 0, 0);
    ef = refEval(xIn, fa, fo, site, int'(stuckIdx), int'(stuckVal));
    checkOne("yGood",  curTag, yGood, eg);
    checkOne("yFault", curTag, yFault, ef);
    checkOne("mismatch", "R10", mismatch, eg ^ ef);
  endtask

  task automatic step();
    @(negedge clk);
    compareNow();
  endtask

  task automatic sweep();
    for (int v = 0; v < 8; v++) begin
      xIn = 3'(v);
      step();
    end
  endtask

  task automatic writeRow(logic plane, logic [1:0] row, logic [5:0] data);
    persWe = 1; persPlane = plane; persRow = row; persData = data;
    step();
    persWe = 0;
  endtask

  task automatic pulseReset();
    rstN = 0;
    step();
    rstN = 1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R1: state during and after reset
    curTag = "R1";
    step(); step();
    rstN = 1;
    sweep();
    // R2, R3, R11: default function across all vectors
    curTag = "R2 R3 R11";
    sweep();
    // R2: empty product row is constant 1
    curTag = "R2";
    writeRow(0, 2'd0, 6'b000000);
    sweep();
    // R3: empty output row is constant 0
    curTag = "R3";
    writeRow(1, 2'd2, 6'b000000);
    sweep();
    // R4: load a row, and a write to a missing OR row is dropped
    curTag = "R4";
    writeRow(0, 2'd1, 6'b010001);
    writeRow(1, 2'd0, 6'b000110);
    sweep();
    writeRow(1, 2'd3, 6'b001111);
    sweep();
    pulseReset();
    curTag = "R1";
    sweep();
    // R5, R6: every AND crosspoint forced absent / present
    faultEn = 1; faultPlane = 0;
    for (int add = 0; add < 2; add++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 6; c++) begin
          curTag = (add == 0) ? "R5" : "R6";
          faultAdd = add[0]; faultRow = 2'(r); faultCol = 3'(c);
          sweep();
        end
    // R7: every OR crosspoint forced absent / present
    faultPlane = 1;
    curTag = "R7";
    for (int add = 0; add < 2; add++)
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 4; c++) begin
          faultAdd = add[0]; faultRow = 2'(r); faultCol = 3'(c);
          sweep();
        end
    // R8: out-of-range descriptors and untouched personality
    curTag = "R8";
    faultPlane = 0; faultRow = 2'd1; faultCol = 3'd7; faultAdd = 1;
    sweep();
    faultPlane = 1; faultRow = 2'd3; faultCol = 3'd0;
    sweep();
    faultPlane = 1; faultRow = 2'd0; faultCol = 3'd5;
    sweep();
    faultEn = 0;
    curTag = "R8 R11";
    sweep();
    // R9: stuck lines at every site and level
    stuckEn = 1;
    curTag = "R9";
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 4; i++)
        for (int l = 0; l < 2; l++) begin
          stuckSite = 2'(s); stuckIdx = 3'(i); stuckVal = l[0];
          sweep();
        end
    stuckEn = 0;
    curTag = "R11";
    sweep();
    finishRun();
  end
endmodule